// File: doc/BRIEF.md
# Periodic DRAM Refresh Scheduler

This block tells a DRAM command controller when an auto-refresh is owed and keeps it informed about when ordinary traffic may flow again. A free-running interval timer, sized from the clock period, produces one refresh obligation every 7.8 us. That pace gives 8192 refreshes in each 64 ms retention window. Obligations accumulate in a debt counter. The controller may let them pile up while it is busy, but once eight are outstanding the request turns urgent, because no more than eight refreshes may be issued back to back.

The controller consumes an obligation by raising its grant while the request is high. It grants only when every bank is already precharged. After each granted refresh the block holds off both ready outputs for the refresh cycle time. A level request from the controller puts the scheduler into self-refresh. In that state no obligations are counted. When the request drops, the debt is cleared and two separate wait windows start: a short one for ordinary commands and a 200-cycle one for reads.

Top module: `refresh_scheduler`

## Requirements
- R1: An interval tick occurs every REFI_CYC clock cycles after reset. That is 390 cycles at the default 20 ns clock, so the first request appears at the 390th clock after reset release. Each tick in normal mode raises the debt by one.
- R2: The request output is high exactly when the block is in normal mode, the debt is non-zero and no refresh recovery window is running.
- R3: A grant is accepted only in a cycle where the request is high, and each accepted grant lowers the debt by one. A grant while the request is low leaves the debt and the ready outputs unchanged.
- R4: In the four clock cycles after an accepted grant (RFC_CYC, 75 ns rounded up), the request and both ready outputs are low. They may rise again on the fifth.
- R5: The debt never exceeds MAX_DEBT (8). The urgent output is high exactly when the debt equals 8 in normal mode.
- R6: A tick that arrives while the debt is 8 and no grant is accepted sets the overflow output. The debt stays at 8, and overflow stays high until reset.
- R7: Self-refresh is entered on the clock after the self-refresh input is sampled high, provided no recovery window is running and no grant is accepted that cycle. Otherwise entry waits for those conditions. While in self-refresh, the request, urgent and both ready outputs are low.
- R8: Ticks during self-refresh leave the debt unchanged. When the self-refresh input is sampled low, the block returns to normal mode with the debt cleared to 0.
- R9: After self-refresh exit, the command-ready output stays low for 4 cycles (75 ns rounded up) and the read-ready output stays low for 200 cycles. Read-ready is never high while command-ready is low.
- R10: Out of reset, the debt is 0, overflow, request, urgent and the self-refresh flag are low, and both ready outputs are high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_gnt | input | 1 | Controller issues a refresh this cycle (all banks idle) |
| sr_req | input | 1 | Level: high asks for self-refresh, low asks for exit |
| ref_req | output | 1 | A refresh is owed |
| ref_urgent | output | 1 | Debt at its cap; refresh must not be deferred |
| sr_active | output | 1 | Block is in self-refresh |
| ready_cmd | output | 1 | Non-read commands may be issued |
| ready_rd | output | 1 | Read commands may be issued |
| debt | output | DEBT_W | Number of outstanding refresh obligations |
| overflow | output | 1 | Sticky: an obligation was lost at the cap |

## Verification
A wrong debt value shows up at the debt and request outputs at the first tick or grant after the fault. A lost or extra tick changes when the request rises relative to reset by a whole interval. A recovery or exit counter with the wrong length moves the rising edge of a ready output by at least one cycle, and the per-clock comparison against the reference model catches that in the same cycle. A mode register stuck in the wrong state is exposed within one cycle by the self-refresh flag and the ready outputs.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;

    typedef enum logic {
        MODE_RUN   = 1'b0,
        MODE_SLEEP = 1'b1
    } rs_mode_e;

    typedef struct packed {
        rs_mode_e mode;
    } rs_ctl_t;

    function automatic int unsigned ceil_cycles(input int unsigned span_ps,
                                                input int unsigned clk_ps);
        return (span_ps + clk_ps - 1) / clk_ps;
    endfunction

endpackage

// File: rtl/rs_interval_timer.sv
`timescale 1ns/1ps
module rs_interval_timer #(
    parameter int unsigned PERIOD = 390
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int unsigned W = (PERIOD > 1) ? $clog2(PERIOD) : 1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = (cnt_q == W'(PERIOD - 1));
        cnt_d = tick ? '0 : cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rs_wait_timer.sv
`timescale 1ns/1ps
module rs_wait_timer #(
    parameter int unsigned LOAD = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic busy
);
    localparam int unsigned W = $clog2(LOAD + 1);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        busy = (cnt_q != '0);
        if (load)      cnt_d = W'(LOAD);
        else if (busy) cnt_d = cnt_q - W'(1);
        else           cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/rs_debt_counter.sv
`timescale 1ns/1ps
module rs_debt_counter #(
    parameter int unsigned MAX_DEBT = 8,
    localparam int unsigned W = $clog2(MAX_DEBT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    input  logic         clr,
    output logic [W-1:0] debt,
    output logic         full,
    output logic         overflow
);
    logic [W-1:0] debt_d, debt_q;
    logic         ovf_d, ovf_q;

    always_comb begin
        full   = (debt_q == W'(MAX_DEBT));
        debt_d = debt_q;
        ovf_d  = ovf_q;
        if (clr) begin
            debt_d = '0;
        end else if (inc && !dec) begin
            if (full) ovf_d  = 1'b1;
            else      debt_d = debt_q + W'(1);
        end else if (!inc && dec && debt_q != '0) begin
            debt_d = debt_q - W'(1);
        end
        debt     = debt_q;
        overflow = ovf_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            debt_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            debt_q <= debt_d;
            ovf_q  <= ovf_d;
        end
    end
endmodule

// File: rtl/refresh_scheduler.sv
`timescale 1ns/1ps
module refresh_scheduler
    import rs_pkg::*;
#(
    parameter int unsigned CLK_PERIOD_PS = 20000,
    parameter int unsigned REFI_PS       = 7800000,
    parameter int unsigned RFC_PS        = 75000,
    parameter int unsigned XS_CMD_PS     = 75000,
    parameter int unsigned XS_RD_CYC     = 200,
    parameter int unsigned MAX_DEBT      = 8,
    localparam int unsigned DEBT_W       = $clog2(MAX_DEBT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_gnt,
    input  logic              sr_req,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic              sr_active,
    output logic              ready_cmd,
    output logic              ready_rd,
    output logic [DEBT_W-1:0] debt,
    output logic              overflow
);
    localparam int unsigned REFI_CYC   = REFI_PS / CLK_PERIOD_PS;
    localparam int unsigned RFC_CYC    = ceil_cycles(RFC_PS, CLK_PERIOD_PS);
    localparam int unsigned XS_CMD_CYC = ceil_cycles(XS_CMD_PS, CLK_PERIOD_PS);

    rs_ctl_t ctl_d, ctl_q;

    logic tick, full;
    logic rfc_busy, xcmd_busy, xrd_busy;
    logic grant_ok, sleep_exit, running;

    rs_interval_timer #(.PERIOD(REFI_CYC)) u_interval (
        .clk(clk), .rst_n(rst_n), .tick(tick)
    );

    rs_debt_counter #(.MAX_DEBT(MAX_DEBT)) u_debt (
        .clk(clk), .rst_n(rst_n),
        .inc(tick && running), .dec(grant_ok), .clr(sleep_exit),
        .debt(debt), .full(full), .overflow(overflow)
    );

    rs_wait_timer #(.LOAD(RFC_CYC)) u_rfc_wait (
        .clk(clk), .rst_n(rst_n), .load(grant_ok), .busy(rfc_busy)
    );

    rs_wait_timer #(.LOAD(XS_CMD_CYC)) u_xcmd_wait (
        .clk(clk), .rst_n(rst_n), .load(sleep_exit), .busy(xcmd_busy)
    );

    rs_wait_timer #(.LOAD(XS_RD_CYC)) u_xrd_wait (
        .clk(clk), .rst_n(rst_n), .load(sleep_exit), .busy(xrd_busy)
    );

    always_comb begin
        running    = (ctl_q.mode == MODE_RUN);
        ref_req    = running && (debt != '0) && !rfc_busy;
        grant_ok   = ref_req && ref_gnt;
        sleep_exit = !running && !sr_req;
        ref_urgent = running && full;
        sr_active  = !running;
        ready_cmd  = running && !rfc_busy && !xcmd_busy;
        ready_rd   = running && !rfc_busy && !xrd_busy;

        ctl_d = ctl_q;
        if (running) begin
            if (sr_req && !rfc_busy && !grant_ok) ctl_d.mode = MODE_SLEEP;
        end else if (sleep_exit) begin
            ctl_d.mode = MODE_RUN;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{mode: MODE_RUN};
        else        ctl_q <= ctl_d;
    end
endmodule

// File: rtl/rs_checker.sv
`timescale 1ns/1ps
module rs_checker #(
    parameter int unsigned MAX_DEBT = 8,
    parameter int unsigned DEBT_W   = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ref_gnt,
    input logic              ref_req,
    input logic              ref_urgent,
    input logic              sr_active,
    input logic              ready_cmd,
    input logic              ready_rd,
    input logic [DEBT_W-1:0] debt,
    input logic              overflow
);
    AST_REQ_NEEDS_DEBT: assert property (@(posedge clk) disable iff (!rst_n) ref_req |-> (debt != '0)); // R2
    AST_GRANT_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n) (ref_req && ref_gnt) |=> (!ref_req && !ready_cmd && !ready_rd)); // R4
    AST_DEBT_CAP: assert property (@(posedge clk) disable iff (!rst_n) debt <= DEBT_W'(MAX_DEBT)); // R5
    AST_URGENT_FULL: assert property (@(posedge clk) disable iff (!rst_n) ref_urgent |-> (debt == DEBT_W'(MAX_DEBT))); // R5
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n) overflow |=> overflow); // R6
    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (!rst_n) sr_active |-> (!ref_req && !ref_urgent && !ready_cmd && !ready_rd)); // R7
    AST_SLEEP_DEBT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (sr_active && $past(sr_active)) |-> $stable(debt)); // R8
    AST_EXIT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) $fell(sr_active) |-> (debt == '0)); // R8
    AST_RD_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n) ready_rd |-> ready_cmd); // R9
endmodule

bind refresh_scheduler rs_checker #(.MAX_DEBT(MAX_DEBT), .DEBT_W(DEBT_W)) u_rs_checker (
    .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .ref_req(ref_req),
    .ref_urgent(ref_urgent), .sr_active(sr_active), .ready_cmd(ready_cmd),
    .ready_rd(ready_rd), .debt(debt), .overflow(overflow)
);

// File: tb/tb_refresh_scheduler.sv
`timescale 1ns/1ps
module tb_refresh_scheduler;
    localparam int REFI = 390;
    localparam int RFC  = 4;
    localparam int XC   = 4;
    localparam int XR   = 200;
    localparam int CAP  = 8;

    logic clk = 1'b0, rst_n = 1'b0, ref_gnt = 1'b0, sr_req = 1'b0;
    logic ref_req, ref_urgent, sr_active, ready_cmd, ready_rd, overflow;
    logic [3:0] debt;

    int checks = 0, errors = 0, cyc = 0;
    bit cmp_en = 1'b0, done = 1'b0;
    int m_cnt = 0, m_debt = 0, m_ovf = 0, m_sr = 0, m_rfc = 0, m_xc = 0, m_xr = 0;

    refresh_scheduler dut (
        .clk(clk), .rst_n(rst_n), .ref_gnt(ref_gnt), .sr_req(sr_req),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .sr_active(sr_active),
        .ready_cmd(ready_cmd), .ready_rd(ready_rd), .debt(debt), .overflow(overflow)
    );

    always #10 clk = ~clk;

    function automatic int e_req();  return (m_sr == 0 && m_debt != 0 && m_rfc == 0) ? 1 : 0; endfunction
    function automatic int e_urg();  return (m_sr == 0 && m_debt == CAP) ? 1 : 0; endfunction
    function automatic int e_rcmd(); return (m_sr == 0 && m_rfc == 0 && m_xc == 0) ? 1 : 0; endfunction
    function automatic int e_rrd();  return (m_sr == 0 && m_rfc == 0 && m_xr == 0) ? 1 : 0; endfunction

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // behavioural reference model, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_debt = 0; m_ovf = 0; m_sr = 0; m_rfc = 0; m_xc = 0; m_xr = 0; cyc = 0;
        end else begin
            int gok, tck, old_rfc;
            cyc++;
            gok = (e_req() == 1 && ref_gnt) ? 1 : 0;
            tck = (m_cnt == REFI - 1) ? 1 : 0;
            m_cnt = tck ? 0 : m_cnt + 1;
            old_rfc = m_rfc;
            m_rfc = gok ? RFC : (m_rfc > 0 ? m_rfc - 1 : 0);
            m_xc = m_xc > 0 ? m_xc - 1 : 0;
            m_xr = m_xr > 0 ? m_xr - 1 : 0;
            if (m_sr == 0) begin
                if (tck && !gok) begin
                    if (m_debt == CAP) m_ovf = 1; else m_debt++;
                end else if (!tck && gok) m_debt--;
                if (sr_req && old_rfc == 0 && !gok) m_sr = 1;
            end else if (!sr_req) begin
                m_sr = 0; m_debt = 0; m_xc = XC; m_xr = XR;
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && cmp_en && !done) begin
            chk("R2", "ref_req",    int'(ref_req),    e_req());
            chk("R5", "ref_urgent", int'(ref_urgent), e_urg());
            chk("R7", "sr_active",  int'(sr_active),  m_sr);
            chk("R9", "ready_cmd",  int'(ready_cmd),  e_rcmd());
            chk("R9", "ready_rd",   int'(ready_rd),   e_rrd());
            chk("R1", "debt",       int'(debt),       m_debt);
            chk("R6", "overflow",   int'(overflow),   m_ovf);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL R10 watchdog actual=timeout expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n, nc, nr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cmp_en = 1'b1;
        // R10: state straight out of reset
        chk("R10", "reset ref_req", int'(ref_req), 0);
        chk("R10", "reset ready_cmd", int'(ready_cmd), 1);
        chk("R10", "reset ready_rd", int'(ready_rd), 1);
        chk("R10", "reset debt", int'(debt), 0);
        chk("R10", "reset overflow", int'(overflow), 0);
        chk("R10", "reset sr_active", int'(sr_active), 0);

        // R3: grant with no request pending is ignored
        ref_gnt = 1'b1; @(negedge clk); ref_gnt = 1'b0;
        chk("R3", "stray grant debt", int'(debt), 0);
        chk("R3", "stray grant ready_cmd", int'(ready_cmd), 1);

        // R1: first obligation after one interval
        while (!ref_req) @(negedge clk);
        chk("R1", "first request cycle", cyc, REFI);
        chk("R1", "debt after tick", int'(debt), 1);

        // R3/R4: accepted grant and refresh recovery
        ref_gnt = 1'b1; @(negedge clk); ref_gnt = 1'b0;
        chk("R3", "debt after grant", int'(debt), 0);
        chk("R4", "ready_rd in recovery", int'(ready_rd), 0);
        n = 0;
        while (!ready_cmd) begin n++; @(negedge clk); end
        chk("R4", "recovery length", n, RFC);

        // R5/R6: fill to the cap, then lose one
        while (!ref_urgent) @(negedge clk);
        chk("R5", "debt at urgent", int'(debt), CAP);
        chk("R6", "no overflow at cap", int'(overflow), 0);
        n = 0;
        while (!overflow) begin n++; @(negedge clk); end
        chk("R6", "overflow one interval later", n, REFI);
        chk("R6", "debt held at cap", int'(debt), CAP);

        // drain with grant held high
        ref_gnt = 1'b1; repeat (60) @(negedge clk); ref_gnt = 1'b0;
        chk("R3", "drained debt", int'(debt), 0);
        chk("R5", "urgent after drain", int'(ref_urgent), 0);
        chk("R6", "overflow sticky", int'(overflow), 1);

        // R7/R8: self-refresh with one obligation outstanding
        while (!ref_req) @(negedge clk);
        sr_req = 1'b1; @(negedge clk);
        chk("R7", "sr_active entry", int'(sr_active), 1);
        chk("R7", "ready_cmd in sleep", int'(ready_cmd), 0);
        repeat (900) @(negedge clk);
        chk("R8", "debt frozen in sleep", int'(debt), 1);
        sr_req = 1'b0; @(negedge clk);
        chk("R8", "sr_active after exit", int'(sr_active), 0);
        chk("R8", "debt cleared on exit", int'(debt), 0);
        nc = 0; nr = 0;
        for (int i = 0; i < 260; i++) begin
            if (!ready_cmd) nc++;
            if (!ready_rd) nr++;
            @(negedge clk);
        end
        chk("R9", "non-read wait after exit", nc, XC);
        chk("R9", "read wait after exit", nr, XR);

        // R7: entry deferred behind a refresh recovery
        while (!ref_req) @(negedge clk);
        ref_gnt = 1'b1; sr_req = 1'b1; @(negedge clk); ref_gnt = 1'b0;
        n = 0;
        while (!sr_active) begin n++; @(negedge clk); end
        chk("R7", "deferred entry delay", n, RFC + 1);
        sr_req = 1'b0;
        repeat (250) @(negedge clk);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule